// File: doc/BRIEF.md
# Keyed Idle-Control Register Bank

This block is the memory-mapped register bank that sits between the bus and the hardware idle sequencers of a multi-core cluster. It holds a master enable that only changes after a two-write unlock pair, a set-only register of per-core power-off requests, a wake-enable register, a status register that mixes software-owned off/vote bits with live idle inputs, a live view of the per-core interrupt-pending lines, two delay registers, a power-down configuration register and one power-up configuration register per core.

Each bus access carries a requester identity. The management controller may raise any request bit. An application core may raise only the bits of its own index. The sequencers see the request flags only while the enable is set. When a sequencer finishes, it returns a one-cycle completion pulse that clears the matching flag. Every value the sequencers need comes out as a registered port. Reads return one cycle after the request.

Top module: `idlectl_regbank`

## Requirements
- R1: After reset every writable register, the enable, the request flags, the read-valid output and all exported control outputs are zero.
- R2: The enable changes only after two consecutive writes to byte offset 0x100. The first carries 0x16aa in bits 31:16. The next bus access is a write that carries 0xaa16 in bits 31:16 and the new enable in bit 0. Reading 0x100 returns the enable in bit 0 and zero in every other bit.
- R3: A second-key write that is not directly preceded by a first-key write has no effect on the enable. A first write with any other key value does not arm the unlock.
- R4: Any bus access, read or write, to another address between the two key writes cancels the pending unlock.
- R5: At offset 0x104, bits 3:0 are per-core power-off requests and bits 19:16 are per-core core-and-cluster power-off requests. Writing 1 sets a bit, writing 0 leaves it unchanged, and reads return both fields.
- R6: A write with the management flag low sets only the two request bits whose core index equals the requester's core number. The other bits in its data are ignored.
- R7: A completion pulse on a core's input clears that core's flag. If a set write and a completion pulse hit the same bit in the same cycle, the bit ends up set.
- R8: The request outputs equal the flags while the enable is 1 and are zero while it is 0. The flags are kept while disabled and can still be read.
- R9: At offset 0x10c, bits 3:0 are per-core wake-enables. They are writable, reset to zero, drive the wake-enable output, and the other bits read zero.
- R10: At offset 0x110, bits 3:0 are the per-core off/vote bits and bit 12 is cluster-off; both are writable and exported. Bit 13 shows the live cluster-idle input and bits 11:8 the live per-core idle inputs; writes do not affect them.
- R11: Offset 0x108 returns the live per-core interrupt-pending inputs in bits 3:0, and writes to it have no effect.
- R12: Offsets 0x140 and 0x144 hold 16-bit delays, 0x148 an 8-bit power-down configuration, and 0x150 + 4*n the 8-bit power-up configuration of core n. All are exported, and bits above each width read zero.
- R13: Read data and read-valid appear in the cycle after a read request, and read-valid is low in cycles that follow no read. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid_i | input | 1 | Bus access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_mgmt_i | input | 1 | Requester is the management controller |
| bus_core_i | input | IDX_W | Requesting application core number |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| core_idle_i | input | NCORE | Per-core idle (waiting for interrupt) |
| cluster_idle_i | input | 1 | Cluster idle |
| irq_pend_i | input | NCORE | Per-core interrupt pending |
| done_off_i | input | NCORE | Completion pulse, core power-off request |
| done_offclu_i | input | NCORE | Completion pulse, core-and-cluster request |
| idle_en_o | output | 1 | Master enable for the sequencers |
| off_req_o | output | NCORE | Gated core power-off requests |
| offclu_req_o | output | NCORE | Gated core-and-cluster power-off requests |
| wake_en_o | output | NCORE | Per-core wake enables |
| cluster_off_o | output | 1 | Cluster-off status bit |
| core_offvote_o | output | NCORE | Per-core off/vote status bits |
| sw_delay_o | output | DLY_W | Power switch delay |
| cfg_delay_o | output | DLY_W | Configuration delay |
| pdn_cfg_o | output | PCFG_W | Power-down configuration |
| pup_cfg_o | output | NCORE*PCFG_W | Power-up configuration, core n at bits n*PCFG_W upward |

## Verification
A software write that raises a request bit and a completion pulse from a sequencer that clears the same bit can land on the same clock edge. The bench drives the completion pulse for core 3 on the same edge as a management write that sets core 3's power-off bit. The flag was already set before that edge. The result is judged by reading back the request register and sampling the gated request output afterwards: the bit must still be set. A separate single pulse on another core, with no write, must clear that core's bit.

// File: rtl/idlectl_pkg.sv
package idlectl_pkg;

  // byte offsets of the register words
  localparam logic [31:0] OFS_EN     = 32'h100;
  localparam logic [31:0] OFS_CLOSE  = 32'h104;
  localparam logic [31:0] OFS_PEND   = 32'h108;
  localparam logic [31:0] OFS_WAKE   = 32'h10c;
  localparam logic [31:0] OFS_STAT   = 32'h110;
  localparam logic [31:0] OFS_SWDLY  = 32'h140;
  localparam logic [31:0] OFS_CFGDLY = 32'h144;
  localparam logic [31:0] OFS_PDN    = 32'h148;
  localparam logic [31:0] OFS_PUP0   = 32'h150;

  // unlock keys, carried in bits 31:16
  localparam logic [15:0] KEY_FIRST  = 16'h16aa;
  localparam logic [15:0] KEY_SECOND = 16'haa16;

  // field positions
  localparam int CLU_REQ_LSB     = 16;
  localparam int STAT_IDLE_LSB   = 8;
  localparam int STAT_CLOFF_BIT  = 12;
  localparam int STAT_CLIDLE_BIT = 13;

  typedef enum logic {UL_IDLE, UL_ARMED} unlock_st_e;

  function automatic logic word_hit(input logic [31:0] a, input logic [31:0] ofs);
    return a[31:2] == ofs[31:2];
  endfunction

endpackage

// File: rtl/idlectl_unlock.sv
module idlectl_unlock
  import idlectl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_i,
  input  logic        wr_i,
  input  logic        hit_i,
  input  logic [15:0] key_i,
  input  logic        val_i,
  output logic        en_o
);

  unlock_st_e st_q, st_n;
  logic       en_n;
  logic       key1_wr, key2_wr;

  assign key1_wr = wr_i && hit_i && (key_i == KEY_FIRST);
  assign key2_wr = wr_i && hit_i && (key_i == KEY_SECOND);

  always_comb begin
    st_n = st_q;
    en_n = en_o;
    if (acc_i) begin
      // only a first-key write leaves the lock armed; anything else drops it
      st_n = key1_wr ? UL_ARMED : UL_IDLE;
      if (st_q == UL_ARMED && key2_wr) begin
        en_n = val_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= UL_IDLE;
      en_o <= 1'b0;
    end else begin
      st_q <= st_n;
      en_o <= en_n;
    end
  end

endmodule

// File: rtl/idlectl_reqflags.sv
module idlectl_reqflags #(
  parameter int NCORE = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic             mgmt_i,
  input  logic [IDX_W-1:0] core_i,
  input  logic [NCORE-1:0] wr_off_i,
  input  logic [NCORE-1:0] wr_clu_i,
  input  logic [NCORE-1:0] done_off_i,
  input  logic [NCORE-1:0] done_clu_i,
  input  logic             en_i,
  output logic [NCORE-1:0] flag_off_o,
  output logic [NCORE-1:0] flag_clu_o,
  output logic [NCORE-1:0] go_off_o,
  output logic [NCORE-1:0] go_clu_o
);

  logic [NCORE-1:0] allow;
  logic [NCORE-1:0] set_off, set_clu;
  logic [NCORE-1:0] off_n, clu_n;

  assign allow   = mgmt_i ? {NCORE{1'b1}} : (NCORE'(1) << core_i);
  assign set_off = set_i ? (wr_off_i & allow) : '0;
  assign set_clu = set_i ? (wr_clu_i & allow) : '0;

  // a set in the same cycle as a completion wins
  assign off_n = (flag_off_o & ~done_off_i) | set_off;
  assign clu_n = (flag_clu_o & ~done_clu_i) | set_clu;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_off_o <= '0;
      flag_clu_o <= '0;
      go_off_o   <= '0;
      go_clu_o   <= '0;
    end else begin
      flag_off_o <= off_n;
      flag_clu_o <= clu_n;
      go_off_o   <= off_n & {NCORE{en_i}};
      go_clu_o   <= clu_n & {NCORE{en_i}};
    end
  end

endmodule

// File: rtl/idlectl_cfgbank.sv
module idlectl_cfgbank
  import idlectl_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int DLY_W  = 16,
  parameter int PCFG_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_i,
  input  logic [31:0]             addr_i,
  input  logic [31:0]             wdata_i,
  output logic [DLY_W-1:0]        sw_dly_o,
  output logic [DLY_W-1:0]        cfg_dly_o,
  output logic [PCFG_W-1:0]       pdn_o,
  output logic [NCORE*PCFG_W-1:0] pup_o,
  output logic                    hit_o,
  output logic [31:0]             rdata_o
);

  logic [PCFG_W-1:0] pup_q [NCORE];
  logic [NCORE-1:0]  pup_hit;

  genvar gn;
  generate
    for (gn = 0; gn < NCORE; gn++) begin : g_pup
      localparam logic [31:0] OFS = OFS_PUP0 + 32'(4 * gn);
      assign pup_hit[gn] = word_hit(addr_i, OFS);
      assign pup_o[gn*PCFG_W +: PCFG_W] = pup_q[gn];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_dly_o  <= '0;
      cfg_dly_o <= '0;
      pdn_o     <= '0;
      for (int n = 0; n < NCORE; n++) pup_q[n] <= '0;
    end else if (wr_i) begin
      if (word_hit(addr_i, OFS_SWDLY))  sw_dly_o  <= wdata_i[DLY_W-1:0];
      if (word_hit(addr_i, OFS_CFGDLY)) cfg_dly_o <= wdata_i[DLY_W-1:0];
      if (word_hit(addr_i, OFS_PDN))    pdn_o     <= wdata_i[PCFG_W-1:0];
      for (int n = 0; n < NCORE; n++) begin
        if (pup_hit[n]) pup_q[n] <= wdata_i[PCFG_W-1:0];
      end
    end
  end

  always_comb begin
    hit_o   = 1'b0;
    rdata_o = '0;
    if (word_hit(addr_i, OFS_SWDLY)) begin
      hit_o   = 1'b1;
      rdata_o = 32'(sw_dly_o);
    end else if (word_hit(addr_i, OFS_CFGDLY)) begin
      hit_o   = 1'b1;
      rdata_o = 32'(cfg_dly_o);
    end else if (word_hit(addr_i, OFS_PDN)) begin
      hit_o   = 1'b1;
      rdata_o = 32'(pdn_o);
    end else begin
      for (int n = 0; n < NCORE; n++) begin
        if (pup_hit[n]) begin
          hit_o   = 1'b1;
          rdata_o = 32'(pup_q[n]);
        end
      end
    end
  end

endmodule

// File: rtl/idlectl_regbank.sv
module idlectl_regbank
  import idlectl_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 12,
  parameter int DLY_W  = 16,
  parameter int PCFG_W = 8,
  localparam int IDX_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_valid_i,
  input  logic                    bus_write_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [31:0]             bus_wdata_i,
  input  logic                    bus_mgmt_i,
  input  logic [IDX_W-1:0]        bus_core_i,
  output logic                    rd_valid_o,
  output logic [31:0]             rd_data_o,
  input  logic [NCORE-1:0]        core_idle_i,
  input  logic                    cluster_idle_i,
  input  logic [NCORE-1:0]        irq_pend_i,
  input  logic [NCORE-1:0]        done_off_i,
  input  logic [NCORE-1:0]        done_offclu_i,
  output logic                    idle_en_o,
  output logic [NCORE-1:0]        off_req_o,
  output logic [NCORE-1:0]        offclu_req_o,
  output logic [NCORE-1:0]        wake_en_o,
  output logic                    cluster_off_o,
  output logic [NCORE-1:0]        core_offvote_o,
  output logic [DLY_W-1:0]        sw_delay_o,
  output logic [DLY_W-1:0]        cfg_delay_o,
  output logic [PCFG_W-1:0]       pdn_cfg_o,
  output logic [NCORE*PCFG_W-1:0] pup_cfg_o
);

  localparam int FIELD_MAX = 4;

  logic [31:0]      a32;
  logic             wr_acc, rd_acc;
  logic             hit_en, hit_close, hit_pend, hit_wake, hit_stat;
  logic [NCORE-1:0] close_off, close_clu;
  logic             cfg_hit;
  logic [31:0]      cfg_rdata;
  logic [31:0]      rd_n;

  assign a32       = 32'(bus_addr_i);
  assign wr_acc    = bus_valid_i && bus_write_i;
  assign rd_acc    = bus_valid_i && !bus_write_i;
  assign hit_en    = word_hit(a32, OFS_EN);
  assign hit_close = word_hit(a32, OFS_CLOSE);
  assign hit_pend  = word_hit(a32, OFS_PEND);
  assign hit_wake  = word_hit(a32, OFS_WAKE);
  assign hit_stat  = word_hit(a32, OFS_STAT);

  idlectl_unlock u_unlock (
    .clk   (clk),
    .rst   (rst),
    .acc_i (bus_valid_i),
    .wr_i  (bus_write_i),
    .hit_i (hit_en),
    .key_i (bus_wdata_i[31:16]),
    .val_i (bus_wdata_i[0]),
    .en_o  (idle_en_o)
  );

  idlectl_reqflags #(.NCORE(NCORE), .IDX_W(IDX_W)) u_req (
    .clk        (clk),
    .rst        (rst),
    .set_i      (wr_acc && hit_close),
    .mgmt_i     (bus_mgmt_i),
    .core_i     (bus_core_i),
    .wr_off_i   (bus_wdata_i[NCORE-1:0]),
    .wr_clu_i   (bus_wdata_i[CLU_REQ_LSB +: NCORE]),
    .done_off_i (done_off_i),
    .done_clu_i (done_offclu_i),
    .en_i       (idle_en_o),
    .flag_off_o (close_off),
    .flag_clu_o (close_clu),
    .go_off_o   (off_req_o),
    .go_clu_o   (offclu_req_o)
  );

  idlectl_cfgbank #(.NCORE(NCORE), .DLY_W(DLY_W), .PCFG_W(PCFG_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (wr_acc),
    .addr_i    (a32),
    .wdata_i   (bus_wdata_i),
    .sw_dly_o  (sw_delay_o),
    .cfg_dly_o (cfg_delay_o),
    .pdn_o     (pdn_cfg_o),
    .pup_o     (pup_cfg_o),
    .hit_o     (cfg_hit),
    .rdata_o   (cfg_rdata)
  );

  // wake enables and software-owned status bits
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_en_o      <= '0;
      cluster_off_o  <= 1'b0;
      core_offvote_o <= '0;
    end else if (wr_acc) begin
      if (hit_wake) wake_en_o <= bus_wdata_i[NCORE-1:0];
      if (hit_stat) begin
        cluster_off_o  <= bus_wdata_i[STAT_CLOFF_BIT];
        core_offvote_o <= bus_wdata_i[NCORE-1:0];
      end
    end
  end

  // read mux
  always_comb begin
    rd_n = '0;
    if (hit_en) begin
      rd_n[0] = idle_en_o;
    end else if (hit_close) begin
      rd_n[NCORE-1:0]             = close_off;
      rd_n[CLU_REQ_LSB +: NCORE]  = close_clu;
    end else if (hit_pend) begin
      rd_n[NCORE-1:0] = irq_pend_i;
    end else if (hit_wake) begin
      rd_n[NCORE-1:0] = wake_en_o;
    end else if (hit_stat) begin
      rd_n[STAT_CLIDLE_BIT]          = cluster_idle_i;
      rd_n[STAT_CLOFF_BIT]           = cluster_off_o;
      rd_n[STAT_IDLE_LSB +: NCORE]   = core_idle_i;
      rd_n[NCORE-1:0]                = core_offvote_o;
    end else if (cfg_hit) begin
      rd_n = cfg_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_acc;
      if (rd_acc) rd_data_o <= rd_n;
    end
  end

  initial begin
    if (NCORE > FIELD_MAX) $error("NCORE exceeds the per-core field width");
  end

endmodule

// File: rtl/idlectl_regbank_chk.sv
module idlectl_regbank_chk
  import idlectl_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              bus_mgmt_i,
  input logic [IDX_W-1:0]  bus_core_i,
  input logic              rd_valid_o,
  input logic              idle_en_o,
  input logic [NCORE-1:0]  off_req_o,
  input logic [NCORE-1:0]  offclu_req_o,
  input logic [NCORE-1:0]  close_off,
  input logic [NCORE-1:0]  close_clu
);

  logic             key2_wr, close_wr;
  logic [NCORE-1:0] own;

  assign key2_wr  = bus_valid_i && bus_write_i && word_hit(32'(bus_addr_i), OFS_EN)
                    && (bus_wdata_i[31:16] == KEY_SECOND);
  assign close_wr = bus_valid_i && bus_write_i && word_hit(32'(bus_addr_i), OFS_CLOSE);
  assign own      = NCORE'(1) << bus_core_i;

  AST_EN_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    (idle_en_o != $past(idle_en_o)) |-> $past(key2_wr)); // R2

  AST_FLAG_RISE_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (((close_off & ~$past(close_off)) | (close_clu & ~$past(close_clu))) != '0)
      |-> $past(close_wr)); // R5

  AST_FOREIGN_BIT_NEEDS_MGMT: assert property (@(posedge clk) disable iff (rst)
    ((((close_off & ~$past(close_off)) | (close_clu & ~$past(close_clu))) & ~$past(own)) != '0)
      |-> $past(bus_mgmt_i)); // R6

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ((off_req_o | offclu_req_o) != '0) |-> $past(idle_en_o)); // R8

  AST_REQ_WITHIN_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ((off_req_o & ~close_off) | (offclu_req_o & ~close_clu)) == '0); // R8

  AST_RDVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(bus_valid_i && !bus_write_i)); // R13

endmodule

bind idlectl_regbank idlectl_regbank_chk #(
  .NCORE(NCORE), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_mgmt_i   (bus_mgmt_i),
  .bus_core_i   (bus_core_i),
  .rd_valid_o   (rd_valid_o),
  .idle_en_o    (idle_en_o),
  .off_req_o    (off_req_o),
  .offclu_req_o (offclu_req_o),
  .close_off    (close_off),
  .close_clu    (close_clu)
);

// File: tb/sim_idlectl_regbank.sv
`timescale 1ns/1ps
module sim_idlectl_regbank;

  localparam int NCORE  = 4;
  localparam int ADDR_W = 12;
  localparam int DLY_W  = 16;
  localparam int PCFG_W = 8;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    bus_valid_i = 1'b0;
  logic                    bus_write_i = 1'b0;
  logic [ADDR_W-1:0]       bus_addr_i = '0;
  logic [31:0]             bus_wdata_i = '0;
  logic                    bus_mgmt_i = 1'b1;
  logic [1:0]              bus_core_i = '0;
  logic                    rd_valid_o;
  logic [31:0]             rd_data_o;
  logic [NCORE-1:0]        core_idle_i = '0;
  logic                    cluster_idle_i = 1'b0;
  logic [NCORE-1:0]        irq_pend_i = '0;
  logic [NCORE-1:0]        done_off_i = '0;
  logic [NCORE-1:0]        done_offclu_i = '0;
  logic                    idle_en_o;
  logic [NCORE-1:0]        off_req_o, offclu_req_o, wake_en_o, core_offvote_o;
  logic                    cluster_off_o;
  logic [DLY_W-1:0]        sw_delay_o, cfg_delay_o;
  logic [PCFG_W-1:0]       pdn_cfg_o;
  logic [NCORE*PCFG_W-1:0] pup_cfg_o;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  idlectl_regbank #(.NCORE(NCORE), .ADDR_W(ADDR_W), .DLY_W(DLY_W), .PCFG_W(PCFG_W)) u0 (
    .clk(clk), .rst(rst),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_mgmt_i(bus_mgmt_i), .bus_core_i(bus_core_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .core_idle_i(core_idle_i), .cluster_idle_i(cluster_idle_i), .irq_pend_i(irq_pend_i),
    .done_off_i(done_off_i), .done_offclu_i(done_offclu_i),
    .idle_en_o(idle_en_o), .off_req_o(off_req_o), .offclu_req_o(offclu_req_o),
    .wake_en_o(wake_en_o), .cluster_off_o(cluster_off_o), .core_offvote_o(core_offvote_o),
    .sw_delay_o(sw_delay_o), .cfg_delay_o(cfg_delay_o), .pdn_cfg_o(pdn_cfg_o),
    .pup_cfg_o(pup_cfg_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] addr, input logic [31:0] data,
                        input logic mgmt = 1'b1, input logic [1:0] core = 2'd0);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = addr[ADDR_W-1:0];
    bus_wdata_i = data; bus_mgmt_i = mgmt; bus_core_i = core;
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_mgmt_i = 1'b1; bus_core_i = '0;
  endtask

  task automatic bus_rd(input logic [31:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = addr[ADDR_W-1:0];
    @(negedge clk);
    bus_valid_i = 1'b0;
    chk("R13 read valid", 32'(rd_valid_o), 32'd1);
    data = rd_data_o;
  endtask

  task automatic set_en(input logic v);
    bus_wr(32'h100, 32'h16aa_0000);
    bus_wr(32'h100, {16'haa16, 15'h7fff, v});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 idle_en_o", 32'(idle_en_o), 0);
    chk("R1 requests", {off_req_o, offclu_req_o, wake_en_o, core_offvote_o}, 0);
    chk("R1 cfg outputs", {sw_delay_o, cfg_delay_o}, 0);
    chk("R1 pup/pdn", pup_cfg_o | 32'(pdn_cfg_o) | 32'(cluster_off_o), 0);
    bus_rd(32'h100, d); chk("R1 enable read", d, 0);
    bus_rd(32'h104, d); chk("R1 request read", d, 0);
    bus_rd(32'h10c, d); chk("R1 wake read", d, 0);
    bus_rd(32'h110, d); chk("R1 status read", d, 0);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    set_en(1'b1);
    bus_rd(32'h100, d); chk("R2 enable set, reserved zero", d, 32'h1);
    chk("R2 idle_en_o", 32'(idle_en_o), 1);
    bus_wr(32'h100, 32'haa16_0000);
    bus_rd(32'h100, d); chk("R3 lone second key", d, 32'h1);
    bus_wr(32'h100, 32'h1234_0000);
    bus_wr(32'h100, 32'haa16_0000);
    bus_rd(32'h100, d); chk("R3 wrong first key", d, 32'h1);
    bus_wr(32'h100, 32'h16aa_0000);
    bus_rd(32'h10c, d);
    bus_wr(32'h100, 32'haa16_0000);
    bus_rd(32'h100, d); chk("R4 read between keys", d, 32'h1);
    bus_wr(32'h100, 32'h16aa_0000);
    bus_wr(32'h10c, 32'h0);
    bus_wr(32'h100, 32'haa16_0000);
    bus_rd(32'h100, d); chk("R4 write between keys", d, 32'h1);
    set_en(1'b0);
    bus_rd(32'h100, d); chk("R2 enable cleared", d, 32'h0);
    chk("R2 idle_en_o low", 32'(idle_en_o), 0);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    set_en(1'b1);
    bus_wr(32'h104, 32'h0005_0002);
    bus_rd(32'h104, d); chk("R5 set by one", d, 32'h0005_0002);
    bus_wr(32'h104, 32'h0);
    bus_rd(32'h104, d); chk("R5 zero no effect", d, 32'h0005_0002);
    bus_wr(32'h104, 32'h0008_0008, 1'b0, 2'd0);
    bus_rd(32'h104, d); chk("R6 foreign bits ignored", d, 32'h0005_0002);
    bus_wr(32'h104, 32'h000F_000F, 1'b0, 2'd3);
    bus_rd(32'h104, d); chk("R6 own bits only", d, 32'h000D_000A);
    chk("R8 off_req_o enabled", 32'(off_req_o), 32'hA);
    chk("R8 offclu_req_o enabled", 32'(offclu_req_o), 32'hD);
    @(negedge clk); done_off_i = 4'h2;
    @(negedge clk); done_off_i = 4'h0;
    bus_rd(32'h104, d); chk("R7 completion clears", d, 32'h000D_0008);
    // collision: set and completion on core 3 together
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = 12'h104;
    bus_wdata_i = 32'h0000_0008; bus_mgmt_i = 1'b1; done_off_i = 4'h8;
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0; done_off_i = 4'h0;
    bus_rd(32'h104, d); chk("R7 set wins over completion", d, 32'h000D_0008);
    chk("R7 output after collision", 32'(off_req_o), 32'h8);
    @(negedge clk); done_offclu_i = 4'h1;
    @(negedge clk); done_offclu_i = 4'h0;
    bus_rd(32'h104, d); chk("R7 cluster completion clears", d, 32'h000C_0008);
    set_en(1'b0);
    @(negedge clk);
    chk("R8 outputs gated off", {off_req_o, offclu_req_o}, 0);
    bus_rd(32'h104, d); chk("R8 flags kept while disabled", d, 32'h000C_0008);
  endtask

  task automatic t_wake_stat_pend();
    logic [31:0] d;
    bus_wr(32'h10c, 32'hFFFF_FFFF);
    bus_rd(32'h10c, d); chk("R9 wake read", d, 32'hF);
    chk("R9 wake_en_o", 32'(wake_en_o), 32'hF);
    core_idle_i = 4'b1010; cluster_idle_i = 1'b1;
    bus_wr(32'h110, 32'hFFFF_FFFF);
    bus_rd(32'h110, d); chk("R10 status read", d, 32'h0000_3A0F);
    chk("R10 exported status", {cluster_off_o, core_offvote_o}, 32'h1F);
    core_idle_i = 4'b0000; cluster_idle_i = 1'b0;
    bus_rd(32'h110, d); chk("R10 live idle bits", d, 32'h0000_100F);
    irq_pend_i = 4'b0110;
    bus_wr(32'h108, 32'hFFFF_FFFF);
    bus_rd(32'h108, d); chk("R11 pending live", d, 32'h6);
    irq_pend_i = 4'b0000;
    bus_rd(32'h108, d); chk("R11 write ignored", d, 32'h0);
  endtask

  task automatic t_cfg_read();
    logic [31:0] d;
    bus_wr(32'h140, 32'hFFFF_1234);
    bus_wr(32'h144, 32'hABCD_5678);
    bus_wr(32'h148, 32'h0000_01FF);
    bus_wr(32'h158, 32'hFFFF_FF3C);
    bus_rd(32'h140, d); chk("R12 switch delay", d, 32'h1234);
    bus_rd(32'h144, d); chk("R12 config delay", d, 32'h5678);
    bus_rd(32'h148, d); chk("R12 power-down cfg", d, 32'hFF);
    bus_rd(32'h158, d); chk("R12 power-up cfg core 2", d, 32'h3C);
    chk("R12 pup_cfg_o", pup_cfg_o, 32'h003C_0000);
    chk("R12 delay outputs", {sw_delay_o, cfg_delay_o}, 32'h1234_5678);
    bus_rd(32'h1F0, d); chk("R13 unmapped reads zero", d, 32'h0);
    @(negedge clk);
    chk("R13 valid low without read", 32'(rd_valid_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_flags();
    t_wake_stat_pend();
    t_cfg_read();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule